// File: doc/BRIEF.md
# Instruction Pointer and Branch Unit

This unit holds the instruction pointer of a 64-bit machine whose control-flow immediates count in words rather than bytes. The pointer is the fetch address. On every cycle in which the step strobe is high, one instruction is consumed and the pointer is updated once. The unit first moves the pointer forward by one word (8 bytes). It then applies the control-flow opcode, if there is one, on top of that advanced value.

The unit compares two register values itself to resolve the conditional branches. It uses the first of them as the target of an indirect jump. When a linking form is taken, it raises a write request for the return register (index 62) during the step cycle, and the write data is the advanced pointer. Memory, the register file and arithmetic are outside the unit. The surrounding core supplies the opcode, the immediate and the two register values, and it performs the link write.

Top module: `ipbu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `fetch_addr` becomes 0, and `link_we` is low whenever `step` is low.
- R2: When `step` is low, `fetch_addr` keeps its value across the clock edge, whatever the other inputs are.
- R3: On a step whose opcode is none of 0x50 to 0x56, the next `fetch_addr` is the current value plus 8 (the advanced pointer), and no link is requested.
- R4: Opcode 0x50 is taken when `reg_a` equals `reg_b`. When taken, the next pointer is the advanced pointer plus the sign-extended 32-bit `imm` times 8. Otherwise the next pointer is the advanced pointer.
- R5: Opcode 0x52 is taken when `reg_a` differs from `reg_b`, with the same target arithmetic as R4.
- R6: Opcodes 0x51 (equal) and 0x53 (not equal) branch exactly as 0x50 and 0x52. When taken, and only then, `link_we` is high in the step cycle with `link_idx` = 62 and `link_data` = the advanced pointer.
- R7: Opcode 0x54 sets the next pointer to the zero-extended `imm` times 8, ignoring the current pointer.
- R8: Opcode 0x56 always raises the link request with the advanced pointer as data and index 62, and it jumps as in R7.
- R9: Opcode 0x55 loads the next pointer from `reg_a` unchanged, with no scaling.
- R10: `link_we` is never high unless `step` is high and the opcode is 0x51, 0x53 or 0x56.
- R11: All pointer arithmetic wraps modulo 2^64.
- R12: `next_addr` always shows the value the pointer takes if the current cycle is a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | One instruction is consumed this cycle |
| opcode | input | 8 | Opcode of the instruction being consumed |
| imm | input | 32 | Immediate: word offset or word target |
| reg_a | input | 64 | First register operand value |
| reg_b | input | 64 | Second register operand value |
| fetch_addr | output | 64 | Current instruction pointer (byte address) |
| next_addr | output | 64 | Pointer value after a step with the present inputs |
| link_we | output | 1 | Return-register write request |
| link_idx | output | 6 | Register index for the link write (62) |
| link_data | output | 64 | Link data: the advanced pointer |

## Verification
On every cycle, the assertions check that the pointer holds without a step, that it moves by one word for ordinary opcodes, and that indirect and absolute jumps land on their targets. They also check that a link request only appears on a step with a linking opcode and always carries the advanced pointer to register 62. Several behaviours are shown only by the bench scenarios: the taken and not-taken outcomes of each conditional form, the sign handling of backward offsets, the wrap at the top of the address space, and the reset value. In those scenarios a reference model computes every expected pointer.

// File: rtl/ipbu_pkg.sv
// Package: shared constants and decoded-control type for the pointer unit.
// Assumes 8-bit opcodes whose control-flow values sit in 0x50..0x56.
package ipbu_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_BR_EQ       = 8'h50;
    localparam logic [OPC_W-1:0] OPC_BR_EQ_LINK  = 8'h51;
    localparam logic [OPC_W-1:0] OPC_BR_NE       = 8'h52;
    localparam logic [OPC_W-1:0] OPC_BR_NE_LINK  = 8'h53;
    localparam logic [OPC_W-1:0] OPC_JMP_ABS     = 8'h54;
    localparam logic [OPC_W-1:0] OPC_JMP_IND     = 8'h55;
    localparam logic [OPC_W-1:0] OPC_JMP_LINK    = 8'h56;

    // Which address source the next pointer uses.
    typedef enum logic [1:0] {
        FLOW_SEQ = 2'd0,
        FLOW_REL = 2'd1,
        FLOW_ABS = 2'd2,
        FLOW_IND = 2'd3
    } flow_e;

    // Decoded control for one instruction.
    typedef struct packed {
        flow_e flow;
        logic  conditional;
        logic  cond_ne;
        logic  link;
    } ctrl_t;

endpackage

// File: rtl/ipbu_decode.sv
// Module: ipbu_decode
// Turns an opcode into flow-control fields. Any opcode outside the
// control-flow set decodes to plain sequential flow with no link.
module ipbu_decode
    import ipbu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    // Map each control-flow opcode onto its source, condition and link bit.
    always_comb begin
        ctrl = '{flow: FLOW_SEQ, conditional: 1'b0, cond_ne: 1'b0, link: 1'b0};
        unique case (opcode)
            OPC_BR_EQ:      ctrl = '{flow: FLOW_REL, conditional: 1'b1, cond_ne: 1'b0, link: 1'b0};
            OPC_BR_EQ_LINK: ctrl = '{flow: FLOW_REL, conditional: 1'b1, cond_ne: 1'b0, link: 1'b1};
            OPC_BR_NE:      ctrl = '{flow: FLOW_REL, conditional: 1'b1, cond_ne: 1'b1, link: 1'b0};
            OPC_BR_NE_LINK: ctrl = '{flow: FLOW_REL, conditional: 1'b1, cond_ne: 1'b1, link: 1'b1};
            OPC_JMP_ABS:    ctrl = '{flow: FLOW_ABS, conditional: 1'b0, cond_ne: 1'b0, link: 1'b0};
            OPC_JMP_IND:    ctrl = '{flow: FLOW_IND, conditional: 1'b0, cond_ne: 1'b0, link: 1'b0};
            OPC_JMP_LINK:   ctrl = '{flow: FLOW_ABS, conditional: 1'b0, cond_ne: 1'b0, link: 1'b1};
            default:        ctrl = '{flow: FLOW_SEQ, conditional: 1'b0, cond_ne: 1'b0, link: 1'b0};
        endcase
    end

endmodule

// File: rtl/ipbu_addr_calc.sv
// Module: ipbu_addr_calc
// Computes every candidate next address in parallel: sequential,
// relative (signed word offset), absolute (unsigned word target) and
// indirect (register value). Assumes WORD_BYTES is a power of two and
// PTR_W > IMM_W. All sums wrap modulo 2^PTR_W.
module ipbu_addr_calc #(
    parameter int PTR_W      = 64,
    parameter int IMM_W      = 32,
    parameter int WORD_BYTES = 8
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [IMM_W-1:0] imm,
    input  logic [PTR_W-1:0] reg_a,
    output logic [PTR_W-1:0] seq_addr,
    output logic [PTR_W-1:0] rel_addr,
    output logic [PTR_W-1:0] abs_addr,
    output logic [PTR_W-1:0] ind_addr
);

    localparam int SHIFT   = $clog2(WORD_BYTES);
    localparam int EXT_W   = PTR_W - IMM_W;

    logic [PTR_W-1:0] imm_sx;
    logic [PTR_W-1:0] imm_zx;

    // Widen the immediate both ways.
    always_comb begin
        imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
        imm_zx = {{EXT_W{1'b0}}, imm};
    end

    // Form the four candidate addresses.
    always_comb begin
        seq_addr = ptr + PTR_W'(WORD_BYTES);
        rel_addr = seq_addr + (imm_sx << SHIFT);
        abs_addr = imm_zx << SHIFT;
        ind_addr = reg_a;
    end

endmodule

// File: rtl/ipbu_next_sel.sv
// Module: ipbu_next_sel
// Resolves the branch condition and picks the next pointer from the
// candidates; raises a link request when a linking form is taken.
module ipbu_next_sel
    import ipbu_pkg::*;
#(
    parameter int PTR_W = 64
) (
    input  ctrl_t            ctrl,
    input  logic             regs_equal,
    input  logic [PTR_W-1:0] seq_addr,
    input  logic [PTR_W-1:0] rel_addr,
    input  logic [PTR_W-1:0] abs_addr,
    input  logic [PTR_W-1:0] ind_addr,
    output logic [PTR_W-1:0] next_addr,
    output logic             link_req
);

    logic taken;

    // A conditional form is taken when equality matches its sense.
    always_comb begin
        if (ctrl.conditional)
            taken = regs_equal ^ ctrl.cond_ne;
        else
            taken = (ctrl.flow != FLOW_SEQ);
    end

    // Select the next address; untaken branches fall back to sequential.
    always_comb begin
        next_addr = seq_addr;
        if (taken) begin
            unique case (ctrl.flow)
                FLOW_REL: next_addr = rel_addr;
                FLOW_ABS: next_addr = abs_addr;
                FLOW_IND: next_addr = ind_addr;
                default:  next_addr = seq_addr;
            endcase
        end
    end

    // Link only on a taken linking form.
    always_comb link_req = ctrl.link && taken;

endmodule

// File: rtl/ipbu.sv
// Module: ipbu (top)
// Holds the instruction pointer and updates it once per step strobe.
// Assumes the surrounding core presents opcode, immediate and the two
// register values in the step cycle, and performs the link write itself.
module ipbu
    import ipbu_pkg::*;
#(
    parameter int PTR_W      = 64,
    parameter int IMM_W      = 32,
    parameter int WORD_BYTES = 8,
    parameter int RIDX_W     = 6,
    parameter int RET_REG    = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PTR_W-1:0]  reg_a,
    input  logic [PTR_W-1:0]  reg_b,
    output logic [PTR_W-1:0]  fetch_addr,
    output logic [PTR_W-1:0]  next_addr,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [PTR_W-1:0]  link_data
);

    ctrl_t            ctrl;
    logic             regs_equal;
    logic             link_req;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] seq_addr, rel_addr, abs_addr, ind_addr;

    ipbu_decode u_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    ipbu_addr_calc #(
        .PTR_W      (PTR_W),
        .IMM_W      (IMM_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_calc (
        .ptr      (ptr_q),
        .imm      (imm),
        .reg_a    (reg_a),
        .seq_addr (seq_addr),
        .rel_addr (rel_addr),
        .abs_addr (abs_addr),
        .ind_addr (ind_addr)
    );

    // Register comparison feeding the conditional forms.
    always_comb regs_equal = (reg_a == reg_b);

    ipbu_next_sel #(
        .PTR_W (PTR_W)
    ) u_sel (
        .ctrl       (ctrl),
        .regs_equal (regs_equal),
        .seq_addr   (seq_addr),
        .rel_addr   (rel_addr),
        .abs_addr   (abs_addr),
        .ind_addr   (ind_addr),
        .next_addr  (next_addr),
        .link_req   (link_req)
    );

    // Pointer register: cleared by reset, updated only on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (step)
            ptr_q <= next_addr;
    end

    // Drive the fetch address and the link-write request.
    always_comb begin
        fetch_addr = ptr_q;
        link_we    = step && link_req;
        link_idx   = RIDX_W'(RET_REG);
        link_data  = seq_addr;
    end

endmodule

// File: rtl/ipbu_chk.sv
// Module: ipbu_chk
// Temporal checks on the pointer unit's ports, bound into every ipbu.
module ipbu_chk
    import ipbu_pkg::*;
#(
    parameter int PTR_W      = 64,
    parameter int IMM_W      = 32,
    parameter int WORD_BYTES = 8,
    parameter int RIDX_W     = 6,
    parameter int RET_REG    = 62
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic [OPC_W-1:0]  opcode,
    input logic [IMM_W-1:0]  imm,
    input logic [PTR_W-1:0]  reg_a,
    input logic [PTR_W-1:0]  fetch_addr,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_idx,
    input logic [PTR_W-1:0]  link_data
);

    logic is_flow_op;
    logic is_link_op;

    // Classify the opcode independently of the decoder.
    always_comb begin
        is_flow_op = (opcode >= OPC_BR_EQ) && (opcode <= OPC_JMP_LINK);
        is_link_op = (opcode == OPC_BR_EQ_LINK) || (opcode == OPC_BR_NE_LINK)
                  || (opcode == OPC_JMP_LINK);
    end

    // R2
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(fetch_addr));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !is_flow_op) |=> fetch_addr == $past(fetch_addr) + PTR_W'(WORD_BYTES));

    // R6
    link_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == fetch_addr + PTR_W'(WORD_BYTES))
                    && (link_idx == RIDX_W'(RET_REG)));

    // R10
    link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (step && is_link_op));

    // R8
    call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && opcode == OPC_JMP_LINK) |-> link_we);

    // R9
    ind_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && opcode == OPC_JMP_IND) |=> fetch_addr == $past(reg_a));

    // R7
    abs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && opcode == OPC_JMP_ABS) |=>
            fetch_addr == (PTR_W'($past(imm)) * PTR_W'(WORD_BYTES)));

endmodule

bind ipbu ipbu_chk #(
    .PTR_W      (PTR_W),
    .IMM_W      (IMM_W),
    .WORD_BYTES (WORD_BYTES),
    .RIDX_W     (RIDX_W),
    .RET_REG    (RET_REG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .opcode     (opcode),
    .imm        (imm),
    .reg_a      (reg_a),
    .fetch_addr (fetch_addr),
    .link_we    (link_we),
    .link_idx   (link_idx),
    .link_data  (link_data)
);

// File: tb/ipbu_test.sv
// Bench for ipbu: directed corner cases plus seeded random steps,
// each compared with a reference model written from the requirements.
module ipbu_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step;
    logic [7:0]  opcode;
    logic [31:0] imm;
    logic [63:0] reg_a, reg_b;
    logic [63:0] fetch_addr, next_addr, link_data;
    logic        link_we;
    logic [5:0]  link_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [63:0] model_ptr;

    always #4 clk = ~clk;

    ipbu uut (
        .clk(clk), .rst_n(rst_n), .step(step), .opcode(opcode), .imm(imm),
        .reg_a(reg_a), .reg_b(reg_b), .fetch_addr(fetch_addr),
        .next_addr(next_addr), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: is this opcode's branch/jump taken?
    function automatic bit ref_taken(logic [7:0] op, logic [63:0] a, logic [63:0] b);
        case (op)
            8'h50, 8'h51: return a == b;
            8'h52, 8'h53: return a != b;
            8'h54, 8'h55, 8'h56: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Reference next pointer (R3..R9, R11).
    function automatic logic [63:0] ref_next(logic [63:0] p, logic [7:0] op,
                                             logic [31:0] im, logic [63:0] a, logic [63:0] b);
        logic [63:0] adv = p + 64'd8;
        if (!ref_taken(op, a, b)) return adv;
        case (op)
            8'h54, 8'h56: return {32'd0, im} * 64'd8;
            8'h55:        return a;
            default:      return adv + ($signed({{32{im[31]}}, im}) * 64'sd8);
        endcase
    endfunction

    function automatic bit ref_link(logic [7:0] op, logic [63:0] a, logic [63:0] b);
        return (op == 8'h51 || op == 8'h53 || op == 8'h56) && ref_taken(op, a, b);
    endfunction

    // One step: drive at negedge, check link/next mid-cycle, pointer after edge.
    task automatic do_step(string tag, logic [7:0] op, logic [31:0] im,
                           logic [63:0] a, logic [63:0] b);
        logic [63:0] exp_n;
        bit          exp_l;
        @(negedge clk);
        step = 1'b1; opcode = op; imm = im; reg_a = a; reg_b = b;
        exp_n = ref_next(model_ptr, op, im, a, b);
        exp_l = ref_link(op, a, b);
        #1;
        check({tag, " R12 next_addr"}, next_addr, exp_n);
        check({tag, " R6/R10 link_we"}, {63'd0, link_we}, {63'd0, exp_l});
        if (exp_l) begin
            check({tag, " R6/R8 link_data"}, link_data, model_ptr + 64'd8);
            check({tag, " R6/R8 link_idx"}, {58'd0, link_idx}, 64'd62);
        end
        @(posedge clk);
        #1;
        model_ptr = exp_n;
        check({tag, " ptr"}, fetch_addr, exp_n);
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; step = 1'b0; opcode = 8'h00; imm = '0; reg_a = '0; reg_b = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset ptr", fetch_addr, 64'd0);
        check("R1 link idle", {63'd0, link_we}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        model_ptr = 64'd0;

        // R2: idle cycles with busy inputs leave the pointer alone.
        @(negedge clk);
        opcode = 8'h56; imm = 32'h1234; reg_a = 64'd5; reg_b = 64'd5;
        #1;
        check("R2/R10 link without step", {63'd0, link_we}, 64'd0);
        repeat (2) @(posedge clk);
        #1;
        check("R2 hold", fetch_addr, 64'd0);

        do_step("R3 nop", 8'h00, 32'd99, 64'd1, 64'd2);
        do_step("R3 add-like", 8'h10, 32'hFFFF_FFFF, 64'd1, 64'd1);
        do_step("R4 beq taken", 8'h50, 32'd10, 64'd7, 64'd7);
        do_step("R4 beq not taken", 8'h50, 32'd10, 64'd7, 64'd8);
        do_step("R4 beq backward", 8'h50, 32'hFFFF_FFFD, 64'd3, 64'd3);
        do_step("R5 bne taken", 8'h52, 32'd4, 64'd1, 64'd2);
        do_step("R5 bne not taken", 8'h52, 32'd4, 64'd9, 64'd9);
        do_step("R6 beq-link taken", 8'h51, 32'd2, 64'd0, 64'd0);
        do_step("R6 beq-link not taken", 8'h51, 32'd2, 64'd0, 64'd1);
        do_step("R6 bne-link taken", 8'h53, 32'hFFFF_FFFF, 64'd0, 64'd1);
        do_step("R6 bne-link not taken", 8'h53, 32'd6, 64'd4, 64'd4);
        do_step("R7 jump abs", 8'h54, 32'h8000_0001, 64'd0, 64'd0);
        do_step("R8 call", 8'h56, 32'd100, 64'd0, 64'd0);
        do_step("R9 jump reg", 8'h55, 32'd7, 64'h0000_1234_5678_9ABD, 64'd0);
        do_step("R11 to top", 8'h55, 32'd0, 64'hFFFF_FFFF_FFFF_FFF8, 64'd1);
        do_step("R11 wrap", 8'h00, 32'd0, 64'd0, 64'd0);
        do_step("R11 back wrap", 8'h50, 32'hFFFF_FFF0, 64'd0, 64'd0);

        // Random steps mixing control and plain opcodes.
        for (int i = 0; i < 1500; i++) begin
            logic [7:0]  op;
            logic [63:0] a, b;
            int sel = $urandom_range(0, 9);
            op = (sel < 7) ? (8'h50 + 8'(sel)) : 8'($urandom_range(0, 255));
            a  = {$urandom(), $urandom()};
            b  = ($urandom_range(0, 1) == 1) ? a : {$urandom(), $urandom()};
            do_step("R3-R9 random", op, $urandom(), a, b);
            if ($urandom_range(0, 7) == 0) begin
                @(posedge clk);
                #1;
                check("R2 random hold", fetch_addr, model_ptr);
            end
        end

        // R1: reset mid-run clears the pointer.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", fetch_addr, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        model_ptr = 64'd0;
        do_step("R3 after reset", 8'h01, 32'd0, 64'd0, 64'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule